// File: doc/BRIEF.md
# Tapped Delay-Line Time-to-Digital Converter

This block measures how many clock periods separate a start event from a stop event and reports the result as a small binary code. It models a delay-line converter in synthesizable form. A level on the start input is pushed down a chain of `2**RES_BITS - 1` register stages, one stage per clock tick. The rising edge of stop freezes a copy of every tap at once. That frozen thermometer word is encoded to binary.

Start acts as an arm and clear. While start is low, the chain and the captured word read all zeros. While start is high, the level advances along the chain. Only the first stop edge of a start period is measured. A result becomes visible with a one-cycle valid strobe and is held until the next measurement. Both inputs are asynchronous to the clock, so each passes through a synchronizer before it is used.

Top module: `tdc_delay_line`

## Requirements
- R1: With RES_BITS = 3 the chain has exactly seven stages, and `therm_o` is seven bits wide, with bit 0 being the first stage.
- R2: While synchronized start is low, every chain stage and the captured word are zero, and `therm_o` reads zero from the fourth falling clock edge after `start_i` falls.
- R3: If `start_i` and `stop_i` rise with D rising clock edges between them, driven at the same clock phase, then `code_o` equals min(D, 7).
- R4: `therm_o` holds the captured taps as a thermometer word. Its lowest `code_o` bits are one and all others are zero.
- R5: Only the first rising edge of stop after start goes high is captured. Later stop edges during the same start-high period are ignored, and so is a stop edge while start is low. In both cases `valid_o` stays low and `code_o` and `therm_o` are unchanged.
- R6: `valid_o` is high for exactly one cycle, after the fourth rising clock edge following the rise of `stop_i`. `code_o` changes only together with `valid_o` and otherwise holds.
- R7: When all seven taps are set at capture, `overflow_o` is 1 and `code_o` is 7. Otherwise `overflow_o` is 0.
- R8: The encoder outputs the index of the highest set tap plus one. If the word has a one above a zero (a bubble), it sets `bubble_o`. For example, 0000101 encodes to 3 with the flag set, and 1000000 encodes to 7 with the flag set.
- R9: After reset, `code_o`, `therm_o`, `valid_o`, `overflow_o` and `bubble_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; one period per stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start level; arms the chain and clears it while low |
| stop_i | input | 1 | Stop event; its rising edge captures the taps |
| therm_o | output | 7 | Captured thermometer word |
| code_o | output | 3 | Binary result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| overflow_o | output | 1 | All taps were set at capture |
| bubble_o | output | 1 | Captured word was not a clean thermometer code |

## Verification
The bench uses the default parameters: three result bits, which gives seven stages, and a two-flop synchronizer. With only seven stages, a start-to-stop distance a little above seven cycles is enough to drive the chain into saturation and overflow. The full five-edge window around each strobe can also be checked explicitly. A chain driven only by start never holds a bubbled pattern, so the bench builds a second instance of the encoder alone and feeds it malformed words.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned TDC_RES_BITS_DEF = 3;
  localparam int unsigned TDC_SYNC_DEF     = 2;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else if (g == 0) pipe_q[g] <= d_i;
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/tdc_chain.sv
module tdc_chain #(
  parameter int unsigned STAGES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              grab_i,
  output logic [STAGES-1:0] cap_o
);
  logic [STAGES-1:0] tap_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[g] <= 1'b0;
      else if (g == 0) tap_q[g] <= arm_i;
      else tap_q[g] <= arm_i & tap_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_o <= '0;
    else if (!arm_i)  cap_o <= '0;
    else if (grab_i)  cap_o <= tap_q;
  end
endmodule

// File: rtl/tdc_encoder.sv
module tdc_encoder #(
  parameter int unsigned STAGES   = 7,
  parameter int unsigned RES_BITS = 3
) (
  input  logic [STAGES-1:0]   therm_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                bubble_o,
  output logic                full_o
);
  logic [STAGES-1:0] inc;

  always_comb begin
    code_o = '0;
    for (int i = 0; i < STAGES; i++)
      if (therm_i[i]) code_o = RES_BITS'(i + 1);
  end

  // a clean word plus one is a power of two with no overlap
  assign inc      = therm_i + STAGES'(1);
  assign bubble_o = |(therm_i & inc);
  assign full_o   = &therm_i;
endmodule

// File: rtl/tdc_delay_line.sv
module tdc_delay_line #(
  parameter int unsigned RES_BITS   = tdc_pkg::TDC_RES_BITS_DEF,
  parameter int unsigned SYNC_DEPTH = tdc_pkg::TDC_SYNC_DEF,
  localparam int unsigned STAGES    = (1 << RES_BITS) - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  output logic [STAGES-1:0]   therm_o,
  output logic [RES_BITS-1:0] code_o,
  output logic                valid_o,
  output logic                overflow_o,
  output logic                bubble_o
);
  logic [1:0]          sync_s;
  logic                start_s, stop_s, stop_q, stop_rise;
  logic                armed_q, fire, fire_q;
  logic [RES_BITS-1:0] enc_code;
  logic                enc_bubble, enc_full;

  tdc_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({stop_i, start_i}), .q_o(sync_s)
  );
  assign start_s = sync_s[0];
  assign stop_s  = sync_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b0;
      armed_q <= 1'b1;
      fire_q  <= 1'b0;
    end else begin
      stop_q <= stop_s;
      fire_q <= fire;
      if (!start_s)       armed_q <= 1'b1;
      else if (stop_rise) armed_q <= 1'b0;
    end
  end

  assign stop_rise = stop_s & ~stop_q;
  assign fire      = start_s & stop_rise & armed_q;

  tdc_chain #(.STAGES(STAGES)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(start_s), .grab_i(fire), .cap_o(therm_o)
  );

  tdc_encoder #(.STAGES(STAGES), .RES_BITS(RES_BITS)) u_enc (
    .therm_i(therm_o), .code_o(enc_code), .bubble_o(enc_bubble), .full_o(enc_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o     <= '0;
      overflow_o <= 1'b0;
      bubble_o   <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= fire_q;
      if (fire_q) begin
        code_o     <= enc_code;
        overflow_o <= enc_full;
        bubble_o   <= enc_bubble;
      end
    end
  end
endmodule

// File: rtl/tdc_delay_line_chk.sv
module tdc_delay_line_chk #(
  parameter int unsigned RES_BITS = 3,
  parameter int unsigned STAGES   = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_s,
  input logic [STAGES-1:0]   therm_o,
  input logic [RES_BITS-1:0] code_o,
  input logic                valid_o,
  input logic                overflow_o
);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_s |=> therm_o == '0);

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && therm_o != '0) |-> int'(code_o) == $countones(therm_o));

  p_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (therm_o & STAGES'(therm_o + 1'b1)) == '0);

  p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o));

  p_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> int'(code_o) == STAGES);
endmodule

bind tdc_delay_line tdc_delay_line_chk #(.RES_BITS(RES_BITS), .STAGES(STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_s(start_s), .therm_o(therm_o),
  .code_o(code_o), .valid_o(valid_o), .overflow_o(overflow_o)
);

// File: tb/sim_tdc_delay_line.sv
module sim_tdc_delay_line;
  localparam int RB = 3;
  localparam int ST = 7;
  localparam int NV = 8;
  localparam int D_TAB [NV] = '{0, 1, 2, 3, 4, 6, 7, 11};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [ST-1:0] therm_o;
  logic [RB-1:0] code_o;
  logic valid_o, overflow_o, bubble_o;

  logic [ST-1:0] t_enc = '0;
  logic [RB-1:0] e_code;
  logic e_bub, e_full;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tdc_delay_line u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .therm_o(therm_o), .code_o(code_o), .valid_o(valid_o),
    .overflow_o(overflow_o), .bubble_o(bubble_o)
  );

  tdc_encoder #(.STAGES(ST), .RES_BITS(RB)) u_enc_only (
    .therm_i(t_enc), .code_o(e_code), .bubble_o(e_bub), .full_o(e_full)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int d);
    int e = (d > ST) ? ST : d;
    @(negedge clk);
    start_i = 1'b1;
    repeat (d) @(negedge clk);
    stop_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 4) begin
        chk(valid_o == 1'b1, "R6 strobe", int'(valid_o), 1);
        chk(int'(code_o) == e, "R3 code", int'(code_o), e);
        chk(int'(therm_o) == (1 << e) - 1, "R4 therm", int'(therm_o), (1 << e) - 1);
        chk(overflow_o == (e == ST), "R7 overflow", int'(overflow_o), int'(e == ST));
        chk(bubble_o == 1'b0, "R8 no bubble", int'(bubble_o), 0);
      end else begin
        chk(valid_o == 1'b0, "R6 quiet", int'(valid_o), 0);
      end
    end
    stop_i  = 1'b0;
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(therm_o == '0, "R2 clear", int'(therm_o), 0);
    chk(int'(code_o) == e, "R6 hold", int'(code_o), e);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c0;
    logic [ST-1:0] w0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(code_o == '0 && therm_o == '0 && !valid_o && !overflow_o && !bubble_o,
        "R9 reset", int'({code_o, therm_o, valid_o, overflow_o, bubble_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk($bits(therm_o) == 7, "R1 stages", $bits(therm_o), 7);

    for (int i = 0; i < NV; i++) measure(D_TAB[i]);

    // R5 second stop in the same start period is ignored
    @(negedge clk);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    stop_i = 1'b1;
    repeat (5) @(negedge clk);
    c0 = int'(code_o);
    w0 = therm_o;
    chk(c0 == 3, "R3 pre-ignore", c0, 3);
    stop_i = 1'b0;
    repeat (3) @(negedge clk);
    stop_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R5 late stop", int'(valid_o), 0);
    end
    chk(int'(code_o) == c0, "R5 code kept", int'(code_o), c0);
    chk(therm_o == w0, "R5 therm kept", int'(therm_o), int'(w0));

    // R5 stop edge while start is low is ignored
    start_i = 1'b0;
    stop_i  = 1'b0;
    repeat (4) @(negedge clk);
    stop_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R5 stop while idle", int'(valid_o), 0);
    end
    chk(int'(code_o) == c0, "R5 idle code kept", int'(code_o), c0);
    chk(therm_o == '0, "R5 idle therm", int'(therm_o), 0);
    stop_i = 1'b0;

    // R8 encoder with malformed words
    t_enc = 7'b0000101; #1;
    chk(int'(e_code) == 3 && e_bub, "R8 bubble low", int'({e_code, e_bub}), 7);
    t_enc = 7'b1000000; #1;
    chk(int'(e_code) == 7 && e_bub && !e_full, "R8 lone top", int'({e_code, e_bub, e_full}), 30);
    t_enc = 7'b0011111; #1;
    chk(int'(e_code) == 5 && !e_bub, "R8 clean", int'({e_code, e_bub}), 10);
    t_enc = 7'b1111111; #1;
    chk(int'(e_code) == 7 && !e_bub && e_full, "R7 full word", int'({e_code, e_bub, e_full}), 29);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule